// File: doc/BRIEF.md
# Buffered Edge/Center-Aligned PWM Timer

A 16-bit timer with a single PWM channel. Software programs it through an 8-bit write bus. The bus gives access to a control byte and to the period limit and duty threshold, each of which is written as a high byte and a low byte. The counter runs in one of two modes:
- **Sawtooth (edge-aligned):** it counts from 0 up to the top value and wraps to 0.
- **Triangle (center-aligned):** it counts from 0 up to the top value and back down to 0.

The output level comes from comparing the count against the duty threshold.

Both 16-bit values pass through a shadow stage. A value counts as written only once both of its bytes have arrived, in either order. While the counter runs, the completed value moves into the active register only when the count steps up from top-1 to top. A change therefore never cuts a period in two. When the clock-select field is zero the counter is stopped, and a completed value goes straight to the active register.

A limit of zero means free-running, with a top value of 0xFFFF. A sticky overflow flag marks each return of the counter to zero. A debug-halt input lets a control write drop a half-written period limit.

Top module: `pwm_tmr`

## Requirements
- R1: After reset the counter is stopped at 0, `pwm_out` is 0 and `ovf_flag` is 0.
- R2: Byte addresses are 3 (duty high), 4 (duty low), 1 (limit high) and 2 (limit low). A single byte write leaves the active value unchanged. Once the second byte of a pair arrives, in either order, the full value is used.
- R3: The control byte at address 0 holds the clock select in bits [1:0] (00 means stopped, anything else means run) and the mode in bit 2 (0 = sawtooth). In sawtooth mode the period is top+1 cycles, and the output is high while count < the duty in effect, giving `min(duty, top+1)` high cycles.
- R4: A pending value becomes active on the running step from top-1 to top. A limit of 0 gives top = 0xFFFF. In sawtooth mode a new duty governs from the next period. In triangle mode it governs the down-counting half of the current period.
- R5: In triangle mode the count runs 0..top..1, so the period is 2*top cycles. The output is high while count < duty, giving `2*duty-1` high cycles for 0 < duty < top.
- R6: In triangle mode a duty of top or more gives 100% high. A duty of top-1 leaves exactly 3 low cycles per period.
- R7: A duty changed from 0 to non-zero gives no high cycle until the next period starts. A duty changed from non-zero to 0 lets the current period finish with the old duty.
- R8: With clock select 00 the counter holds its value and no overflow occurs. A completed pair becomes active without any counter event.
- R9: `ovf_flag` is set when the counter returns to 0. It stays set until a control write with bit 7 = 1. A set and a clear in the same cycle leave it set.
- R10: A control write while `dbg_halt` = 1 discards a partly written period limit. Without `dbg_halt`, the partial byte survives and the next opposite byte completes the pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | 3 | Byte register address |
| bus_wdata | input | 8 | Byte write data |
| dbg_halt | input | 1 | Debug-halt state; qualifies control writes |
| pwm_out | output | 1 | PWM channel output |
| ovf_flag | output | 1 | Sticky counter-overflow flag |

## Verification
A wrong shadow or pending state shows up as a wrong count of high cycles. It appears either in the period that straddles a mid-period write or in the period after it, so any such fault is visible within two periods of the write. A counter or direction fault changes both the spacing of `ovf_flag` events and the duty count in the very period where it happens. The bench therefore aligns to an overflow, counts high cycles over whole periods, and checks that the next overflow arrives exactly one period later.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 3'd0,
        RA_LIM_HI = 3'd1,
        RA_LIM_LO = 3'd2,
        RA_DTY_HI = 3'd3,
        RA_DTY_LO = 3'd4
    } reg_addr_e;

    // control byte layout
    localparam int CB_SEL_LO = 0;
    localparam int CB_MODE   = 2;
    localparam int CB_OVFCLR = 7;

    typedef struct packed {
        logic [1:0] clk_sel;
        logic       tri_mode;
    } ctrl_t;

    // limit of zero selects free-running operation
    function automatic logic [CNT_W-1:0] top_of(input logic [CNT_W-1:0] lim);
        return (lim == '0) ? '1 : lim;
    endfunction

endpackage

// File: rtl/pwm_tmr_shadow.sv
module pwm_tmr_shadow #(
    parameter int            W     = 16,
    parameter int            BW    = 8,
    parameter int            NB    = W / BW,
    parameter logic [W-1:0]  RST_V = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NB-1:0] lane_we,
    input  logic [BW-1:0] wdata,
    input  logic          seq_clr,
    input  logic          load,
    output logic [W-1:0]  active
);
    logic [W-1:0]  stage_q, assembled, pend_val_q, act_q;
    logic [NB-1:0] seen_q;
    logic          pend_q, complete;

    for (genvar l = 0; l < NB; l++) begin : g_lane
        assign assembled[l*BW +: BW] = lane_we[l] ? wdata : stage_q[l*BW +: BW];
    end

    assign complete = (|lane_we) && ((seen_q | lane_we) == {NB{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q    <= '0;
            seen_q     <= '0;
            pend_q     <= 1'b0;
            pend_val_q <= '0;
            act_q      <= RST_V;
        end else begin
            stage_q <= assembled;
            if (seq_clr || complete)
                seen_q <= '0;
            else
                seen_q <= seen_q | lane_we;
            if (complete) begin
                pend_val_q <= assembled;
                pend_q     <= 1'b1;
            end else if (load) begin
                pend_q <= 1'b0;
            end
            if (load && pend_q)
                act_q <= pend_val_q;
        end
    end

    assign active = act_q;
endmodule

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tri_mode,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic         up,
    output logic         at_load,
    output logic         wrap
);
    logic [W-1:0] cnt_q, cnt_n;
    logic         up_q, up_n, up_eff;

    always_comb begin
        up_eff = tri_mode ? up_q : 1'b1;
        if (!run)
            cnt_n = cnt_q;
        else if (!tri_mode)
            cnt_n = (cnt_q >= top) ? '0 : cnt_q + W'(1);
        else if (up_eff)
            cnt_n = (cnt_q >= top) ? cnt_q - W'(1) : cnt_q + W'(1);
        else
            cnt_n = (cnt_q == '0) ? cnt_q + W'(1) : cnt_q - W'(1);

        if (!tri_mode || cnt_n == '0)
            up_n = 1'b1;
        else if (run && up_eff && cnt_q >= top)
            up_n = 1'b0;
        else
            up_n = up_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else begin
            cnt_q <= cnt_n;
            up_q  <= up_n;
        end
    end

    assign cnt     = cnt_q;
    assign up      = up_q;
    assign at_load = run && up_eff && (cnt_q == top - W'(1));
    assign wrap    = run && (cnt_n == '0) && (cnt_q != '0);
endmodule

// File: rtl/pwm_tmr_compare.sv
module pwm_tmr_compare #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tri_mode,
    input  logic         wrap,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] top,
    input  logic [W-1:0] duty,
    output logic         pwm
);
    logic [W-1:0] duty_start_q, duty_eff;

    // duty value captured at each period start
    always_ff @(posedge clk) begin
        if (rst)
            duty_start_q <= '0;
        else if (!run || wrap)
            duty_start_q <= duty;
    end

    always_comb begin
        duty_eff = (duty == '0 || duty_start_q == '0) ? duty_start_q : duty;
        if (tri_mode)
            pwm = (duty_eff != '0) && ((duty_eff >= top) || (cnt < duty_eff));
        else
            pwm = cnt < duty_start_q;
    end
endmodule

// File: rtl/pwm_tmr.sv
module pwm_tmr
    import pwm_tmr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          dbg_halt,
    output logic          pwm_out,
    output logic          ovf_flag
);
    localparam int NB = CW / DW;

    ctrl_t        ctrl_q;
    logic         ovf_q, run, ctrl_we, at_load, wrap, cnt_up, load;
    logic [CW-1:0] lim_act, duty_act, top_val, cnt;
    logic [NB-1:0] lim_we, duty_we;
    reg_addr_e     ra;

    assign ra      = reg_addr_e'(bus_addr);
    assign ctrl_we = bus_we && (ra == RA_CTRL);
    assign lim_we  = {bus_we && (ra == RA_LIM_HI), bus_we && (ra == RA_LIM_LO)};
    assign duty_we = {bus_we && (ra == RA_DTY_HI), bus_we && (ra == RA_DTY_LO)};
    assign run     = |ctrl_q.clk_sel;
    assign top_val = top_of(lim_act);
    assign load    = !run || at_load;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (ctrl_we) begin
                ctrl_q.clk_sel  <= bus_wdata[CB_SEL_LO +: 2];
                ctrl_q.tri_mode <= bus_wdata[CB_MODE];
            end
            if (wrap)
                ovf_q <= 1'b1;
            else if (ctrl_we && bus_wdata[CB_OVFCLR])
                ovf_q <= 1'b0;
        end
    end

    pwm_tmr_shadow #(.W(CW), .BW(DW)) u_lim (
        .clk(clk), .rst(rst), .lane_we(lim_we), .wdata(bus_wdata),
        .seq_clr(ctrl_we && dbg_halt), .load(load), .active(lim_act)
    );

    pwm_tmr_shadow #(.W(CW), .BW(DW)) u_duty (
        .clk(clk), .rst(rst), .lane_we(duty_we), .wdata(bus_wdata),
        .seq_clr(1'b0), .load(load), .active(duty_act)
    );

    pwm_tmr_counter #(.W(CW)) u_cnt (
        .clk(clk), .rst(rst), .run(run), .tri_mode(ctrl_q.tri_mode),
        .top(top_val), .cnt(cnt), .up(cnt_up), .at_load(at_load), .wrap(wrap)
    );

    pwm_tmr_compare #(.W(CW)) u_cmp (
        .clk(clk), .rst(rst), .run(run), .tri_mode(ctrl_q.tri_mode),
        .wrap(wrap), .cnt(cnt), .top(top_val), .duty(duty_act), .pwm(pwm_out)
    );

    assign ovf_flag = ovf_q;
endmodule

// File: rtl/pwm_tmr_chk.sv
module pwm_tmr_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         run,
    input logic         tri_mode,
    input logic         up,
    input logic [W-1:0] cnt,
    input logic [W-1:0] top,
    input logic [W-1:0] duty,
    input logic         ovf_flag,
    input logic         bus_we,
    input logic [2:0]   bus_addr,
    input logic         clr_bit
);
    logic up_eff;
    assign up_eff = tri_mode ? up : 1'b1;

    AST_RST_CLEAR: assert property (@(posedge clk) rst |=> (cnt == '0 && !ovf_flag)); // R1

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cnt)); // R8

    AST_SAW_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && !tri_mode && cnt < top) |=> (cnt == $past(cnt) + W'(1))); // R3

    AST_TRI_TURN: assert property (@(posedge clk) disable iff (rst)
        (run && tri_mode && up && top > W'(1) && cnt == top) |=> (cnt == $past(cnt) - W'(1) && !up)); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !(bus_we && bus_addr == 3'd0 && clr_bit)) |=> ovf_flag); // R9

    AST_DUTY_SAFE: assert property (@(posedge clk) disable iff (rst)
        (run && !(up_eff && cnt == top - W'(1))) |=> $stable(duty)); // R4
endmodule

bind pwm_tmr pwm_tmr_chk #(.W(CW)) u_chk (
    .clk(clk), .rst(rst), .run(run), .tri_mode(ctrl_q.tri_mode), .up(cnt_up),
    .cnt(cnt), .top(top_val), .duty(duty_act), .ovf_flag(ovf_flag),
    .bus_we(bus_we), .bus_addr(bus_addr), .clr_bit(bus_wdata[7])
);

// File: tb/pwm_tmr_tb.sv
`timescale 1ns/1ps
module pwm_tmr_tb;
    logic       clk = 1'b0, rst = 1'b1, bus_we = 1'b0, dbg_halt = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       pwm_out, ovf_flag;
    logic [7:0] ctrl_v = 8'h00;
    int n_chk = 0, n_err = 0;

    localparam logic [2:0] A_CTRL = 3'd0, A_LHI = 3'd1, A_LLO = 3'd2, A_DHI = 3'd3, A_DLO = 3'd4;

    always #2 clk = ~clk;

    pwm_tmr u_dut (.clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
                   .bus_wdata(bus_wdata), .dbg_halt(dbg_halt),
                   .pwm_out(pwm_out), .ovf_flag(ovf_flag));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_hi(input bit tri_m, input int top, input int duty);
        if (!tri_m) return (duty > top) ? top + 1 : duty;
        if (duty >= top) return 2 * top;
        if (duty == 0) return 0;
        return 2 * duty - 1;
    endfunction

    function automatic int per_of(input bit tri_m, input int top);
        return tri_m ? 2 * top : top + 1;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic set_ctrl(input logic [7:0] v);
        ctrl_v = v;
        wr(A_CTRL, v);
    endtask

    task automatic wr16(input logic [2:0] ahi, input logic [15:0] v);
        wr(ahi, v[15:8]);
        wr(ahi + 3'd1, v[7:0]);
    endtask

    task automatic cfg(input bit tri_m, input logic [15:0] lim, input logic [15:0] duty);
        set_ctrl({5'b0, tri_m, 2'b00});
        wr16(A_LHI, lim);
        wr16(A_DHI, duty);
        repeat (3) @(negedge clk);
        set_ctrl({5'b0, tri_m, 2'b01});
    endtask

    task automatic align();
        bit found = 0;
        wr(A_CTRL, ctrl_v | 8'h80);
        for (int k = 0; k < 140000; k++) begin
            if (ovf_flag) begin found = 1; break; end
            @(negedge clk);
        end
        if (!found) chk("ALIGN overflow seen", 0, 1);
    endtask

    // count high cycles over nper periods starting at count 0; optional mid-period duty write
    task automatic window(input int P, input int nper, input bit do_wr, input logic [15:0] v,
                          output int h0, output int h1, output bit ovf_ok);
        bit ob = 1, oa = 0;
        h0 = 0; h1 = 0;
        for (int i = 0; i <= nper * P; i++) begin
            if (i < nper * P && pwm_out) begin
                if (i < P) h0++; else h1++;
            end
            if (i == P - 1) ob = ovf_flag;
            if (i == P) oa = ovf_flag;
            if (i == 0) begin bus_we = 1; bus_addr = A_CTRL; bus_wdata = ctrl_v | 8'h80; end
            else if (do_wr && i == 2) begin bus_we = 1; bus_addr = A_DHI; bus_wdata = v[15:8]; end
            else if (do_wr && i == 3) begin bus_we = 1; bus_addr = A_DLO; bus_wdata = v[7:0]; end
            else bus_we = 0;
            @(negedge clk);
        end
        bus_we = 0;
        ovf_ok = !ob && oa;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int h0, h1;
        bit ok;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        chk("R1 pwm after reset", int'(pwm_out), 0);
        chk("R1 ovf after reset", int'(ovf_flag), 0);
        repeat (20) @(negedge clk);
        chk("R8 no overflow while stopped", int'(ovf_flag), 0);

        // stopped: completed pair becomes active without counter events
        wr16(A_DHI, 16'hFFFF);
        repeat (2) @(negedge clk);
        chk("R8 direct load high", int'(pwm_out), 1);
        wr16(A_DHI, 16'h0000);
        repeat (2) @(negedge clk);
        chk("R8 direct load low", int'(pwm_out), 0);

        // sawtooth basic + byte-pair coherency
        cfg(0, 16'd20, 16'd5);
        align(); window(21, 1, 0, 0, h0, h1, ok);
        chk("R3 sawtooth duty 5/21", h0, 5);
        chk("R9 overflow one period later", int'(ok), 1);
        wr(A_DLO, 8'd9);
        align(); align(); window(21, 1, 0, 0, h0, h1, ok);
        chk("R2 lone low byte ignored", h0, 5);
        wr(A_DHI, 8'd0);
        align(); align(); window(21, 1, 0, 0, h0, h1, ok);
        chk("R2 pair complete low-then-high", h0, 9);

        // mid-period update in sawtooth mode
        align(); window(21, 2, 1, 16'd12, h0, h1, ok);
        chk("R4 sawtooth current period keeps old", h0, 9);
        chk("R4 sawtooth next period new", h1, 12);
        align(); window(21, 2, 1, 16'd0, h0, h1, ok);
        chk("R7 sawtooth nonzero->0 old period", h0, 12);
        chk("R7 sawtooth nonzero->0 next", h1, 0);
        align(); window(21, 2, 1, 16'd7, h0, h1, ok);
        chk("R7 sawtooth 0->nonzero waits", h0, 0);
        chk("R7 sawtooth 0->nonzero next", h1, 7);

        // sticky flag and clear
        repeat (3) @(negedge clk);
        chk("R9 flag sticky", int'(ovf_flag), 1);
        wr(A_CTRL, ctrl_v | 8'h80);
        chk("R9 flag cleared", int'(ovf_flag), 0);

        // triangle mode
        cfg(1, 16'd10, 16'd4);
        align(); window(20, 1, 0, 0, h0, h1, ok);
        chk("R5 triangle duty 4", h0, 7);
        chk("R5 triangle period 20", int'(ok), 1);
        align(); window(20, 2, 1, 16'd8, h0, h1, ok);
        chk("R4 triangle down half uses new", h0, 11);
        chk("R4 triangle next period", h1, 15);
        align(); window(20, 2, 1, 16'd0, h0, h1, ok);
        chk("R7 triangle nonzero->0 old period", h0, 15);
        chk("R7 triangle nonzero->0 next", h1, 0);
        align(); window(20, 2, 1, 16'd6, h0, h1, ok);
        chk("R7 triangle 0->nonzero waits", h0, 0);
        chk("R7 triangle 0->nonzero next", h1, 11);

        cfg(1, 16'd10, 16'd10);
        align(); window(20, 1, 0, 0, h0, h1, ok);
        chk("R6 duty=top full", h0, 20);
        cfg(1, 16'd10, 16'd9);
        align(); window(20, 1, 0, 0, h0, h1, ok);
        chk("R6 duty=top-1 three low", h0, 17);
        cfg(1, 16'd10, 16'd255);
        align(); window(20, 1, 0, 0, h0, h1, ok);
        chk("R6 duty>top full", h0, 20);

        // debug-halt control write discards partial limit
        cfg(0, 16'd10, 16'd4);
        align(); window(11, 1, 0, 0, h0, h1, ok);
        chk("R10 baseline period 11", int'(ok), 1);
        set_ctrl(8'h00);
        wr(A_LLO, 8'd20);
        dbg_halt = 1'b1; set_ctrl(8'h00); dbg_halt = 1'b0;
        wr(A_LHI, 8'd0);
        repeat (3) @(negedge clk);
        set_ctrl(8'h01);
        align(); window(11, 1, 0, 0, h0, h1, ok);
        chk("R10 halt discard keeps period 11", int'(ok), 1);
        chk("R10 duty unchanged", h0, 4);
        set_ctrl(8'h00);
        wr16(A_LHI, 16'd10);
        wr(A_LLO, 8'd20);
        set_ctrl(8'h00);
        wr(A_LHI, 8'd0);
        repeat (3) @(negedge clk);
        set_ctrl(8'h01);
        align(); window(21, 1, 0, 0, h0, h1, ok);
        chk("R10 no halt pair completes period 21", int'(ok), 1);

        // constrained random
        for (int t = 0; t < 24; t++) begin
            bit tm;
            int m, d;
            tm = 1'($urandom_range(0, 1));
            m  = int'($urandom_range(2, 30));
            d  = int'($urandom_range(0, m + 2));
            cfg(tm, 16'(m), 16'(d));
            align(); window(per_of(tm, m), 1, 0, 0, h0, h1, ok);
            chk(tm ? "R5 random triangle duty" : "R3 random sawtooth duty", h0, exp_hi(tm, m, d));
            chk("R9 random period", int'(ok), 1);
        end

        // free-running: limit 0 means top 0xFFFF
        cfg(0, 16'd0, 16'h8000);
        align(); window(65536, 1, 1, 16'h0100, h0, h1, ok);
        chk("R4 free-running duty half", h0, 32768);
        chk("R4 free-running period 65536", int'(ok), 1);

        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule